// File: doc/BRIEF.md
# Supervisory Reset Pulse Stretcher

This block merges several reset causes into one stretched system reset. Three causes feed it. The first is a supply-valid flag from an external comparator. The second is an active-low push-button line that may bounce or pick up noise. The third is a single-cycle pulse from a watchdog when it expires. While any cause is active, the block drives an active-low reset and its active-high complement. After the last cause clears, it keeps reset asserted for a fixed recovery time, counted in clock cycles.

The supply flag and the push-button line each pass through a two-flop synchronizer. The push-button line then goes through a filter that accepts a new level only after it has been steady for `GLITCH_CYC` consecutive cycles. A recovery counter starts counting when all causes are gone. Any new cause clears it. A parameter picks one of three recovery lengths: short, middle or long. At a 50 MHz clock, the defaults correspond to about 1.4 ms, 200 ms and 240 ms.

Top module: `sup_rst_stretch`

## Requirements
- R1: Reset asserts when any cause is present: the synchronized supply flag is low, the filtered push-button level is low, or `wdog_exp_i` is high at a clock edge. A supply drop shows at the outputs on the 3rd rising edge after the input changes. A watchdog pulse shows on the 1st rising edge.
- R2: After the supply flag returns high, reset releases on rising edge 2+REC, counted from the edge that first samples the high flag. REC is the selected recovery length.
- R3: Every assertion lasts at least REC cycles. A single-cycle watchdog pulse holds reset for exactly REC cycles.
- R4: A supply drop of any length, including one cycle, clears the recovery count. The full recovery restarts from the supply's final return.
- R5: While the filtered push-button level stays low, reset stays asserted. After the filter sees the line high again, reset lasts one more recovery period.
- R6: A push-button low pulse shorter than `GLITCH_CYC` cycles has no effect on the outputs. A pulse of `GLITCH_CYC` cycles or more asserts reset on rising edge 3+`GLITCH_CYC` after the fall.
- R7: `REC_SEL` picks the recovery length: 0 selects `REC_SHORT`, 1 selects `REC_MID` and 2 selects `REC_LONG`.
- R8: `rst_o` is always the exact inverse of `rst_n_o`.
- R9: Hard reset (`arst_n` low) asserts the reset outputs and clears the recovery count. It also clears the synchronized supply flag to invalid and sets the push-button path to released. As a result, the first release comes 2+REC rising edges after `arst_n` goes high.
- R10: A watchdog pulse that arrives during the recovery period restarts the count. Reset then releases REC cycles after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous hard reset, active low |
| supply_ok_i | input | 1 | Supply-valid flag from the comparator, high when the supply is good |
| man_rst_n_i | input | 1 | Push-button reset, active low, asynchronous and possibly noisy |
| wdog_exp_i | input | 1 | Watchdog expiry, a synchronous one-cycle pulse |
| rst_n_o | output | 1 | Stretched reset, active low |
| rst_o | output | 1 | Stretched reset, active high |

## Verification
The bench sweeps push-button pulse widths across the filter threshold and checks the outputs every cycle. A filter that is off by one cycle would either let a too-short pulse through or miss a pulse of exactly `GLITCH_CYC` cycles. It would also move the assertion or release edge by one cycle. The bench sends a second watchdog pulse at every offset inside the recovery window, including the cycle where release would happen. It also sends one-cycle supply drops at every offset. A counter that is paused instead of cleared, or one that lets release win over a new cause in the same cycle, would then deassert early. The exact release cycle after hard reset and after a supply return pins down both the synchronizer depth and the selected recovery length.

// File: rtl/sup_rst_stretch.sv
`timescale 1ns/1ps
module sup_rst_stretch #(
  parameter int unsigned GLITCH_CYC = 25,
  parameter int unsigned REC_SHORT  = 70000,
  parameter int unsigned REC_MID    = 10000000,
  parameter int unsigned REC_LONG   = 12000000,
  parameter int unsigned REC_SEL    = 1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_ok_i,
  input  logic man_rst_n_i,
  input  logic wdog_exp_i,
  output logic rst_n_o,
  output logic rst_o
);

  localparam int unsigned REC = (REC_SEL == 0) ? REC_SHORT :
                                (REC_SEL == 1) ? REC_MID : REC_LONG;
  localparam int unsigned RW  = $clog2(REC + 1);
  localparam int unsigned GW  = $clog2(GLITCH_CYC + 1);

  logic [1:0]    sup_q, man_q;
  logic          sup_s, man_s;
  logic          mr_f;
  logic [GW-1:0] gcnt;
  logic          cause;
  logic          ast;
  logic [RW-1:0] rc;
  logic [RW-1:0] lo_cnt;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      sup_q <= 2'b00;
      man_q <= 2'b11;
    end else begin
      sup_q <= {sup_q[0], supply_ok_i};
      man_q <= {man_q[0], man_rst_n_i};
    end

  assign sup_s = sup_q[1];
  assign man_s = man_q[1];

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      mr_f <= 1'b1;
      gcnt <= '0;
    end else if (man_s == mr_f) begin
      gcnt <= '0;
    end else if (gcnt == GW'(GLITCH_CYC - 1)) begin
      mr_f <= man_s;
      gcnt <= '0;
    end else begin
      gcnt <= gcnt + 1'b1;
    end

  assign cause = ~sup_s | ~mr_f | wdog_exp_i;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      ast <= 1'b1;
      rc  <= '0;
    end else if (cause) begin
      ast <= 1'b1;
      rc  <= '0;
    end else if (ast) begin
      if (rc == RW'(REC - 1)) begin
        ast <= 1'b0;
        rc  <= '0;
      end else begin
        rc <= rc + 1'b1;
      end
    end

  assign rst_n_o = ~ast;
  assign rst_o   = ast;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)
      lo_cnt <= '0;
    else if (!ast)
      lo_cnt <= '0;
    else if (lo_cnt != RW'(REC))
      lo_cnt <= lo_cnt + 1'b1;

  a_r1_cause_asserts: assert property (@(posedge clk) disable iff (!arst_n)
    cause |=> !rst_n_o);

  a_r3_min_width: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_o) |-> lo_cnt == RW'(REC));

  a_r4_drop_clears: assert property (@(posedge clk) disable iff (!arst_n)
    !sup_s |=> (rc == '0 && rst_o));

  a_r6_filter_follows: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable(mr_f) |-> mr_f == $past(man_s));

  a_r8_complement: assert property (@(posedge clk) disable iff (!arst_n)
    $countones({rst_n_o, rst_o}) == 1);

  a_r10_wdog_restart: assert property (@(posedge clk) disable iff (!arst_n)
    wdog_exp_i |=> (rc == '0 && !rst_n_o));

endmodule

// File: tb/sim_sup_rst_stretch.sv
`timescale 1ns/1ps
module sim_sup_rst_stretch;
  localparam int GL  = 4;
  localparam int RS  = 7;
  localparam int RM  = 10;
  localparam int RL  = 13;
  localparam int REC = RM;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic sup = 1'b1;
  logic mr = 1'b1;
  logic wd = 1'b0;
  logic rn, rh;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sup_rst_stretch #(
    .GLITCH_CYC(GL), .REC_SHORT(RS), .REC_MID(RM), .REC_LONG(RL), .REC_SEL(1)
  ) u0 (
    .clk(clk), .arst_n(arst_n), .supply_ok_i(sup), .man_rst_n_i(mr),
    .wdog_exp_i(wd), .rst_n_o(rn), .rst_o(rh)
  );

  task automatic chk(input logic exp_rn, input string req);
    checks++;
    if (rn !== exp_rn || rh !== ~exp_rn) begin
      fails++;
      $display("FAIL %s: rst_n_o=%b rst_o=%b expected rst_n_o=%b rst_o=%b",
               req, rn, rh, exp_rn, ~exp_rn);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    chk(1'b0, "R9 reset state");
    chk(1'b0, "R8 complement in reset");
    arst_n = 1'b1;
    step(REC + 1);
    chk(1'b0, "R9 still held before release");
    step(1);
    chk(1'b1, "R9 release at 2+REC after hard reset");
    step(3);

    // R1 / R2 / R7: supply drop and return
    sup = 1'b0;
    step(2);
    chk(1'b1, "R1 no assertion before sync latency");
    step(1);
    chk(1'b0, "R1 supply drop asserts");
    step(5);
    sup = 1'b1;
    step(REC + 1);
    chk(1'b0, "R2 held one cycle before release");
    step(1);
    chk(1'b1, "R2 release at 2+REC after supply return");
    chk(1'b1, "R8 complement when released");
    step(3);
    sup = 1'b0;
    step(4);
    sup = 1'b1;
    step(REC + 2);
    chk(1'b1, "R7 middle recovery length selected");
    step(3);

    // R4: one-cycle drop at every offset of recovery
    for (int j = 1; j <= REC; j++) begin
      sup = 1'b0;
      step(4);
      sup = 1'b1;
      step(j);
      sup = 1'b0;
      step(1);
      sup = 1'b1;
      step(REC + 1);
      chk(1'b0, "R4 recovery restarted after short drop");
      step(1);
      chk(1'b1, "R4 release 2+REC after final return");
      step(3);
    end

    // R5 / R6: push-button pulse width sweep
    for (int w = 1; w <= GL + 20; w++) begin
      if (w > GL + 3 && w != GL + 20) continue;
      mr = 1'b0;
      for (int k = 1; k <= 2 + w + GL + REC + 3; k++) begin
        logic e;
        step(1);
        if (w < GL) e = 1'b1;
        else e = (k >= 3 + GL && k < 2 + w + GL + REC) ? 1'b0 : 1'b1;
        if (w < GL) chk(e, "R6 short glitch ignored");
        else if (k < 3 + GL) chk(e, "R6 no assertion before filter window");
        else chk(e, "R5 held while pressed plus recovery");
        if (k == w) mr = 1'b1;
      end
      step(2);
    end

    // R3: single watchdog pulse
    wd = 1'b1;
    for (int k = 1; k <= REC + 1; k++) begin
      step(1);
      wd = 1'b0;
      chk((k <= REC) ? 1'b0 : 1'b1, "R3 single pulse lasts REC cycles");
    end
    step(3);

    // R10: second watchdog pulse at every offset of recovery
    for (int j = 1; j <= REC; j++) begin
      wd = 1'b1;
      for (int k = 1; k <= j + REC + 1; k++) begin
        step(1);
        chk((k <= j + REC) ? 1'b0 : 1'b1, "R10 second pulse restarts recovery");
        wd = (k == j);
      end
      wd = 1'b0;
      step(3);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule